// File: doc/BRIEF.md
# Dual Reload Timer with Shared Interrupt

This block is a register-mapped peripheral with two independent down-counters and one interrupt line. Each timer has a divisor register that holds its reload value and a control register. The control register holds a two-bit operation code (load, hold, run) and a tick-rate select. In run mode a timer counts down once per selected tick, raises its pending bit when it reaches zero, and reloads from its divisor on the following tick, so it repeats periodically.

Pending bits are gated by a mask register, and the interrupt output is high while any unmasked pending bit is set. Software clears pending bits by writing ones to an acknowledge register. A free-running time register counts clock cycles. The bus carries 32-bit words only, and a read returns data one cycle after the address is presented.

Register map (byte offsets): timer 0 divisor 0x00, count 0x04, control 0x08; timer 1 divisor 0x10, count 0x14, control 0x18; time 0x38; mask 0x48; acknowledge 0x4c; masked status 0x50; raw pending 0x54.

Top module: `dual_reload_timer`

## Requirements
- R1: While `rst` is high and after it is released, both timers are stopped with count 0 and control reading 0x1 (hold). Pending and mask read 0 and `irq_out` is low.
- R2: Writing control with op code 0 (load) copies the divisor value held before that cycle into the count and stops the timer. The divisor keeps only its low CNT_W bits.
- R3: While the op code is 1 (hold) or 0, the count does not change.
- R4: With op code 2 (run), each selected tick either decrements a nonzero count or reloads a zero count from the divisor. With divisor D the period is D+1 ticks. A legal control write in a cycle takes the place of that cycle's step.
- R5: A control write with op code 3 is ignored. The control register and the counting behaviour stay as they were.
- R6: Control bits [RATE_W+1:2] hold a rate select s. A timer then ticks on the clock cycles where the low s*RATE_STEP bits of a cycle counter, cleared by reset, are all ones, which is once every 2^(s*RATE_STEP) clocks.
- R7: A running timer expires on a tick that moves its count from 1 to 0, or on any tick while both count and divisor are 0. Expiry of timer 0 sets pending bit 0 and expiry of timer 1 sets pending bit 1.
- R8: `irq_out` is a register. It is high exactly when (pending AND mask) is nonzero, and it follows a mask write or a pending change on the same clock edge that updates them.
- R9: Writing the acknowledge register clears each pending bit whose data bit is 1. An expiry in the same cycle wins. The acknowledge register reads 0.
- R10: Reads return the register addressed in the previous cycle, zero-extended to 32 bits. Offset 0x50 returns pending AND mask. Unmapped or misaligned addresses (address bits [1:0] nonzero) read 0, and writes to them have no effect.
- R11: The time register starts at 0 after reset and increments by one on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after the address |
| irq_out | output | 1 | Shared timer interrupt |

## Verification
The bench builds the block with CNT_W=12 and RATE_STEP=1. Truncation of oversized divisor writes then shows up at a small width. The slowest rate select ticks every 8 clocks, so periodic reloads happen often enough at every rate to be observed many times within a short run. Divisors are kept below 16, so both timers expire repeatedly while acknowledges, mask changes and illegal op codes are mixed in at random.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NUM_TIMERS = 2;

  // timer register offsets relative to the timer base
  localparam int unsigned OFF_DIV     = 'h00;
  localparam int unsigned OFF_CNT     = 'h04;
  localparam int unsigned OFF_CTRL    = 'h08;
  localparam int unsigned OFF_TSTRIDE = 'h10;

  localparam int unsigned OFF_TIME  = 'h38;
  localparam int unsigned OFF_MASK  = 'h48;
  localparam int unsigned OFF_ACK   = 'h4c;
  localparam int unsigned OFF_MSTAT = 'h50;
  localparam int unsigned OFF_PEND  = 'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned RATE_W    = 2,
  parameter int unsigned RATE_STEP = 2,
  localparam int unsigned NSEL     = 2 ** RATE_W,
  localparam int unsigned PRE_W    = (NSEL - 1) * RATE_STEP
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSEL-1:0] tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign tick[0] = 1'b1;
  for (genvar s = 1; s < NSEL; s++) begin : g_tick
    assign tick[s] = &pre_q[s*RATE_STEP-1:0];
  end

  // R6: the slowest rate strobes only when the whole counter is all ones
  a_r6_slowest_tick: assert property (@(posedge clk) disable iff (rst)
    tick[NSEL-1] |=> (pre_q == '0));
endmodule

// File: rtl/reload_counter.sv
module reload_counter
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned RATE_W = 2,
  localparam int unsigned NSEL  = 2 ** RATE_W,
  localparam int unsigned CW    = RATE_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_we,
  input  logic [CNT_W-1:0] div_wdata,
  input  logic             ctrl_we,
  input  logic [CW-1:0]    ctrl_wdata,
  input  logic [NSEL-1:0]  tick_all,
  output logic [CNT_W-1:0] div_q,
  output logic [CW-1:0]    ctrl_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  logic ctrl_ok, running, tick;

  assign ctrl_ok = ctrl_we && (op_e'(ctrl_wdata[1:0]) != OP_BAD);
  assign running = op_e'(ctrl_q[1:0]) == OP_RUN;
  assign tick    = tick_all[ctrl_q[CW-1:2]];
  assign expire  = running && tick && !ctrl_ok &&
                   ((count_q == CNT_W'(1)) || (count_q == '0 && div_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      ctrl_q  <= CW'(OP_HOLD);
      count_q <= '0;
    end else begin
      if (div_we) div_q <= div_wdata;
      if (ctrl_ok) begin
        ctrl_q <= ctrl_wdata;
        if (op_e'(ctrl_wdata[1:0]) == OP_LOAD) count_q <= div_q;
      end else if (running && tick) begin
        count_q <= (count_q == '0) ? div_q : count_q - 1'b1;
      end
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: stopped and cleared right after reset
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_stopped: assert (count_q == '0 && ctrl_q == CW'(OP_HOLD));
    end
  end

  // R3: count frozen unless running or a legal control write lands
  a_r3_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (!running && !ctrl_ok) |=> $stable(count_q));

  // R4: zero count reloads from the divisor on the next tick
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !ctrl_ok && count_q == '0) |=> (count_q == $past(div_q)));

  // R5: illegal op code leaves control unchanged
  a_r5_bad_op_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[1:0] == 2'd3) |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_we,
  input  logic          ack_we,
  input  logic [NT-1:0] wdata,
  input  logic [NT-1:0] expire,
  output logic [NT-1:0] pend_q,
  output logic [NT-1:0] mask_q,
  output logic          irq_out
);
  logic [NT-1:0] pend_n, mask_n, clr;

  always_comb begin
    clr    = ack_we ? wdata : '0;
    pend_n = (pend_q & ~clr) | expire;
    mask_n = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      mask_q  <= mask_n;
      irq_out <= |(pend_n & mask_n);
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: interrupt state cleared after reset
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_irq_cleared: assert (pend_q == '0 && mask_q == '0 && !irq_out);
    end
  end

  // R7: every expiry leaves its pending bit set
  a_r7_expiry_sets: assert property (@(posedge clk) disable iff (rst)
    (|expire) |=> ((pend_q & $past(expire)) == $past(expire)));

  // R9: acknowledged bits clear unless an expiry coincides
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((pend_q & $past(wdata) & ~$past(expire)) == '0));

  // R8: output agrees with the stored pending and mask state
  a_r8_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(pend_q & mask_q)));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned RATE_W    = 2,
  parameter int unsigned RATE_STEP = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out
);
  localparam int unsigned NT   = NUM_TIMERS;
  localparam int unsigned NSEL = 2 ** RATE_W;
  localparam int unsigned CW   = RATE_W + 2;
  localparam int unsigned WW   = ADDR_W - 2;

  function automatic logic [WW-1:0] wofs(input int unsigned off);
    return WW'(off >> 2);
  endfunction

  logic [WW-1:0] widx;
  logic          aligned, wr_ok;
  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_we && aligned;

  logic [NSEL-1:0]  tick_all;
  logic [NT-1:0]    expire, pend_q, mask_q;
  logic [CNT_W-1:0] div_a   [NT];
  logic [CNT_W-1:0] count_a [NT];
  logic [CW-1:0]    ctrl_a  [NT];
  logic [DW-1:0]    time_q;

  tick_prescaler #(.RATE_W(RATE_W), .RATE_STEP(RATE_STEP)) i_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_all)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam int unsigned BASE = t * OFF_TSTRIDE;
    logic div_we, ctrl_we;
    assign div_we  = wr_ok && (widx == wofs(BASE + OFF_DIV));
    assign ctrl_we = wr_ok && (widx == wofs(BASE + OFF_CTRL));

    reload_counter #(.CNT_W(CNT_W), .RATE_W(RATE_W)) i_cnt (
      .clk        (clk),
      .rst        (rst),
      .div_we     (div_we),
      .div_wdata  (bus_wdata[CNT_W-1:0]),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (bus_wdata[CW-1:0]),
      .tick_all   (tick_all),
      .div_q      (div_a[t]),
      .ctrl_q     (ctrl_a[t]),
      .count_q    (count_a[t]),
      .expire     (expire[t])
    );
  end

  irq_gate #(.NT(NT)) i_irq (
    .clk     (clk),
    .rst     (rst),
    .mask_we (wr_ok && (widx == wofs(OFF_MASK))),
    .ack_we  (wr_ok && (widx == wofs(OFF_ACK))),
    .wdata   (bus_wdata[NT-1:0]),
    .expire  (expire),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .irq_out (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) time_q <= '0;
    else     time_q <= time_q + 1'b1;
  end

  logic [DW-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    for (int t = 0; t < NT; t++) begin
      if (widx == wofs(t * OFF_TSTRIDE + OFF_DIV))  rd_n = DW'(div_a[t]);
      if (widx == wofs(t * OFF_TSTRIDE + OFF_CNT))  rd_n = DW'(count_a[t]);
      if (widx == wofs(t * OFF_TSTRIDE + OFF_CTRL)) rd_n = DW'(ctrl_a[t]);
    end
    if (widx == wofs(OFF_TIME))  rd_n = time_q;
    if (widx == wofs(OFF_MASK))  rd_n = DW'(mask_q);
    if (widx == wofs(OFF_MSTAT)) rd_n = DW'(pend_q & mask_q);
    if (widx == wofs(OFF_PEND))  rd_n = DW'(pend_q);
    if (!aligned) rd_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_n;
  end

  // R11: time advances by one every clock
  a_r11_time_step: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (time_q == $past(time_q) + 1'b1));

  // R9: the acknowledge register reads back zero
  a_r9_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (aligned && widx == wofs(OFF_ACK)) |=> (bus_rdata == '0));

  // R10: misaligned reads return zero
  a_r10_misaligned_zero: assert property (@(posedge clk) disable iff (rst)
    (!aligned) |=> (bus_rdata == '0));
endmodule

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
  localparam int CNT_W = 12;
  localparam int RATE_STEP = 1;
  localparam logic [31:0] CMASK = (32'd1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int nchk = 0;
  int nerr = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_reload_timer #(.CNT_W(CNT_W), .RATE_W(2), .RATE_STEP(RATE_STEP), .ADDR_W(8))
    i_dual_reload_timer (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_div [2];
  logic [31:0] m_ctrl[2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_pend, m_mask, m_time, m_rdata;
  logic [7:0]  m_raddr;
  logic        m_irq;
  longint      m_pre;

  function automatic string tag_of(input logic [7:0] a);
    if (a[1:0] != 0) return "R10 misaligned";
    case (a)
      8'h00, 8'h10: return "R2 divisor";
      8'h04, 8'h14: return "R4 R6 count";
      8'h08, 8'h18: return "R5 control";
      8'h38: return "R11 time";
      8'h48: return "R8 mask";
      8'h4c: return "R9 ack";
      8'h50, 8'h54: return "R7 pending";
      default: return "R10 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < 2; t++) begin
        m_div[t] = 0; m_ctrl[t] = 1; m_cnt[t] = 0;
      end
      m_pend = 0; m_mask = 0; m_time = 0; m_rdata = 0; m_irq = 0; m_pre = 0;
      m_raddr = 0;
    end else begin
      logic [31:0] r, e;
      bit al;
      al = (bus_addr[1:0] == 2'b00);
      r = 0;
      if (al) begin
        case (bus_addr)
          8'h00: r = m_div[0];  8'h04: r = m_cnt[0];  8'h08: r = m_ctrl[0];
          8'h10: r = m_div[1];  8'h14: r = m_cnt[1];  8'h18: r = m_ctrl[1];
          8'h38: r = m_time;    8'h48: r = m_mask;
          8'h50: r = m_pend & m_mask;
          8'h54: r = m_pend;
          default: r = 0;
        endcase
      end
      e = 0;
      for (int t = 0; t < 2; t++) begin
        longint p;
        bit tk, cw, dw;
        p  = longint'(1) << ((m_ctrl[t] >> 2) * RATE_STEP);
        tk = (m_pre % p) == p - 1;
        cw = bus_we && al && (bus_addr == 8'(t * 16 + 8)) && (bus_wdata[1:0] != 2'd3);
        dw = bus_we && al && (bus_addr == 8'(t * 16));
        if (cw) begin
          m_ctrl[t] = bus_wdata & 32'hF;
          if (bus_wdata[1:0] == 2'd0) m_cnt[t] = m_div[t];
        end else if (m_ctrl[t][1:0] == 2'd2 && tk) begin
          if (m_cnt[t] == 1 || (m_cnt[t] == 0 && m_div[t] == 0)) e |= (32'd1 << t);
          m_cnt[t] = (m_cnt[t] == 0) ? m_div[t] : m_cnt[t] - 1;
        end
        if (dw) m_div[t] = bus_wdata & CMASK;
      end
      if (bus_we && al && bus_addr == 8'h4c) m_pend = m_pend & ~(bus_wdata & 32'h3);
      m_pend = m_pend | e;
      if (bus_we && al && bus_addr == 8'h48) m_mask = bus_wdata & 32'h3;
      m_irq = (m_pend & m_mask) != 0;
      m_time = m_time + 1;
      m_pre = m_pre + 1;
      m_rdata = r;
      m_raddr = bus_addr;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(rst ? "R1 rdata" : tag_of(m_raddr), bus_rdata, m_rdata);
      chk(rst ? "R1 irq" : "R8 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, lf;
    @(posedge clk);
    @(negedge clk);
    cmp_en = 1'b1;
    idle(3);
    rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(8'h08, v); chk("R1 ctrl0 hold", v, 32'h1);
    rd(8'h48, v); chk("R1 mask zero", v, 32'h0);
    rd(8'h14, v); chk("R1 count1 zero", v, 32'h0);

    wr(8'h00, 32'd5);
    wr(8'h08, 32'h0);
    rd(8'h04, v); chk("R2 load copies divisor", v, 32'd5);
    wr(8'h08, 32'h1);
    rd(8'h04, v); rd(8'h04, v2); chk("R3 hold keeps count", v2, v);

    wr(8'h48, 32'h3);
    wr(8'h08, 32'h2);
    idle(20);
    wr(8'h4c, 32'h1);
    wr(8'h08, 32'hF);
    rd(8'h08, v); chk("R5 illegal op ignored", v, 32'h2);

    wr(8'h10, 32'd3);
    wr(8'h18, 32'h0E);
    idle(80);
    wr(8'h10, 32'd0);
    wr(8'h18, 32'h0);
    wr(8'h18, 32'h6);
    idle(20);
    wr(8'h48, 32'h2); idle(5);
    wr(8'h4c, 32'h3); idle(5);
    wr(8'h48, 32'h0); idle(5);
    wr(8'h48, 32'h1); idle(5);

    rd(8'h4c, v); chk("R9 ack reads zero", v, 32'h0);
    rd(8'h40, v); chk("R10 unmapped reads zero", v, 32'h0);
    rd(8'h06, v); chk("R10 misaligned reads zero", v, 32'h0);
    rd(8'h38, v); rd(8'h38, v2); chk("R11 time step", v2 - v, 32'd2);

    wr(8'h08, 32'h1);
    wr(8'h00, 32'hFFF);
    rd(8'h00, v); chk("R2 divisor max", v, 32'hFFF);
    wr(8'h00, 32'h1234);
    rd(8'h00, v); chk("R2 divisor truncated", v, 32'h234);

    lf = 32'hACE1_2357;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[19:16])
        4'd0: a = 8'h00;  4'd1: a = 8'h04;  4'd2: a = 8'h08;  4'd3: a = 8'h10;
        4'd4: a = 8'h14;  4'd5: a = 8'h18;  4'd6: a = 8'h38;  4'd7: a = 8'h48;
        4'd8: a = 8'h4c;  4'd9: a = 8'h50;  4'd10: a = 8'h54; 4'd11: a = 8'h44;
        4'd12: a = 8'h09; 4'd13: a = 8'h08; 4'd14: a = 8'h18;
        default: a = 8'h50;
      endcase
      @(negedge clk);
      bus_addr = a;
      bus_we = (lf[22:20] < 3'd3);
      bus_wdata = {lf[31:24], 20'd0, lf[11:8]};
      if (lf[25]) begin
        @(negedge clk);
        bus_we = 1'b0;
      end
    end
    @(negedge clk);
    bus_we = 1'b0;
    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule